// File: doc/BRIEF.md
# Logical Shifted-Register Execution Unit

This unit executes the 64-bit logical shifted-register instruction group: AND, ORR, EOR and their inverted-operand forms BIC, ORN and EON, plus the flag-setting ANDS and BICS. It receives one 32-bit instruction word together with the two source values already fetched from the register file. It shifts the second source by the immediate amount and combines it with the first source. It returns the destination value, the destination index with a write enable, new condition flags with their own enable, and an undefined-encoding indication.

A request enters on a valid/ready handshake and its result appears, registered, on an output valid/ready handshake. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output field holds its value and no new request is taken. A request accepted at a clock edge is presented from that edge onward. Register-file access itself is outside the unit. The datapath parameter is meant to stay at 64, because the instruction's 6-bit shift field fixes the width.

Top module: `lsr_alu`

## Requirements
- R1: The function code {insn[21], insn[30:29]} selects the operation: 0 AND, 1 ORR, 2 EOR, 3 ANDS, 4 BIC (a AND NOT b), 5 ORN (a OR NOT b), 6 EON (a XNOR b), 7 BICS. Here a is the Rn value and b is the shifted Rm value.
- R2: insn[23:22] selects the shift applied to the Rm value: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. The shift amount is insn[15:10].
- R3: When insn[31] = 0 (32-bit mode), arithmetic right shift replicates bit 31, and rotation wraps within bits 31:0.
- R4: In 32-bit mode, bits 63:32 of the result are zero for every operation, including the inverted ones.
- R5: When insn[31] = 0 and insn[15] = 1, the encoding is undefined: undef is 1 and both rd_we and flags_we are 0.
- R6: When insn[28:24] differs from 5'b01010, the encoding is undefined, with the same outputs as in R5.
- R7: When insn[30:29] = 3, flags_we is 1 and nzcv = {N, Z, 0, 0}. N is result bit 63 in 64-bit mode and bit 31 in 32-bit mode. Z is 1 when the result is zero. For every other operation, flags_we is 0.
- R8: A source index of 31 in insn[9:5] (Rn) or insn[20:16] (Rm) reads as zero, whatever value is presented on the matching operand port.
- R9: ORR or ORN with shift type 0, shift amount 0 and Rn = 31 returns the Rm value, or its bitwise inverse, truncated and zero-extended in 32-bit mode.
- R10: A shift amount of 0 leaves the Rm value unchanged for all four shift types.
- R11: A request accepted at a clock edge yields out_valid from that edge onward. in_ready = !out_valid || out_ready. While out_valid is high and out_ready is low, all outputs stay stable.
- R12: rd_idx carries insn[4:0]. rd_we is 1 for every defined encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| insn | input | 32 | Instruction word |
| rn_val | input | 64 | First source value |
| rm_val | input | 64 | Second source value, to be shifted |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res | output | 64 | Destination value |
| rd_idx | output | 5 | Destination register index |
| rd_we | output | 1 | Destination write enable |
| nzcv | output | 4 | New flags {N,Z,C,V} |
| flags_we | output | 1 | Flag update enable |
| undef | output | 1 | Encoding is undefined |

## Verification
The unit holds state only in its single output stage. A wrong internal decision therefore shows at the ports in the cycle after the request is taken: a wrong result word, a missing or spurious write or flag enable, or upper bits left set in 32-bit mode. A corrupted output register during back-pressure shows as a changing `res` while `out_valid` is held. A stuck valid shows as `in_ready` staying low after a drain, and the next request then stalls.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_ORR  = 3'd1,
    FN_EOR  = 3'd2,
    FN_ANDS = 3'd3,
    FN_BIC  = 3'd4,
    FN_ORN  = 3'd5,
    FN_EON  = 3'd6,
    FN_BICS = 3'd7
  } logic_fn_e;

  localparam logic [4:0] GROUP_TAG = 5'b01010;

  typedef struct packed {
    logic        wide;
    logic_fn_e   fn;
    shift_kind_e kind;
    logic [4:0]  src_m;
    logic [5:0]  amt;
    logic [4:0]  src_n;
    logic [4:0]  dst;
    logic        bad;
    logic        sets_flags;
  } dec_t;
endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
  import lsr_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  always_comb begin
    dec.wide       = insn[31];
    dec.fn         = logic_fn_e'({insn[21], insn[30:29]});
    dec.kind       = shift_kind_e'(insn[23:22]);
    dec.src_m      = insn[20:16];
    dec.amt        = insn[15:10];
    dec.src_n      = insn[9:5];
    dec.dst        = insn[4:0];
    // Undefined: wrong group tag, or a 32-bit shift of 32 or more.
    dec.bad        = (insn[28:24] != GROUP_TAG) || (!insn[31] && insn[15]);
    dec.sets_flags = (insn[30:29] == 2'd3);
  end
endmodule

// File: rtl/lsr_shifter.sv
module lsr_shifter
  import lsr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]         src,
  input  logic                      wide,
  input  shift_kind_e               kind,
  input  logic [$clog2(DATA_W)-1:0] amt,
  output logic [DATA_W-1:0]         dst
);
  localparam int HALF_W = DATA_W / 2;
  localparam int AMT_W  = $clog2(DATA_W);

  logic [HALF_W-1:0]   lo;
  logic [AMT_W-2:0]    amt_lo;
  logic [DATA_W-1:0]   full_q, lo_pair, lo_rot;
  logic [2*DATA_W-1:0] full_pair;
  logic [HALF_W-1:0]   half_q;

  always_comb begin
    lo        = src[HALF_W-1:0];
    amt_lo    = amt[AMT_W-2:0];
    full_pair = {src, src} >> amt;
    lo_pair   = {lo, lo};
    lo_rot    = lo_pair >> amt_lo;
    unique case (kind)
      SH_LSL:  full_q = src << amt;
      SH_LSR:  full_q = src >> amt;
      SH_ASR:  full_q = DATA_W'($signed(src) >>> amt);
      default: full_q = full_pair[DATA_W-1:0];
    endcase
    unique case (kind)
      SH_LSL:  half_q = lo << amt_lo;
      SH_LSR:  half_q = lo >> amt_lo;
      SH_ASR:  half_q = HALF_W'($signed(lo) >>> amt_lo);
      default: half_q = lo_rot[HALF_W-1:0];
    endcase
    dst = wide ? full_q : {{HALF_W{1'b0}}, half_q};
  end
endmodule

// File: rtl/lsr_logic.sv
module lsr_logic
  import lsr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              wide,
  input  logic_fn_e         fn,
  output logic [DATA_W-1:0] y,
  output logic              neg,
  output logic              zero
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] b_eff, raw;

  always_comb begin
    b_eff = fn[2] ? ~b : b;
    unique case (fn[1:0])
      2'd1:    raw = a | b_eff;
      2'd2:    raw = a ^ b_eff;
      default: raw = a & b_eff;
    endcase
    y    = wide ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    neg  = wide ? y[DATA_W-1] : y[HALF_W-1];
    zero = (y == '0);
  end
endmodule

// File: rtl/lsr_alu.sv
module lsr_alu
  import lsr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       insn,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] rm_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] res,
  output logic [4:0]        rd_idx,
  output logic              rd_we,
  output logic [3:0]        nzcv,
  output logic              flags_we,
  output logic              undef
);
  localparam int HALF_W = DATA_W / 2;
  localparam int AMT_W  = $clog2(DATA_W);
  localparam logic [4:0] ZERO_REG = 5'd31;

  dec_t              dec;
  logic [DATA_W-1:0] op_a, op_b, op_b_sh, logic_y;
  logic              flag_n, flag_z, accept;
  logic [DATA_W-1:0] res_q;
  logic [4:0]        rd_q;
  logic              we_q, fwe_q, undef_q;
  logic [3:0]        nzcv_q;

  lsr_decode u_dec (.insn(insn), .dec(dec));

  always_comb begin
    op_a = (dec.src_n == ZERO_REG) ? '0 : rn_val;
    op_b = (dec.src_m == ZERO_REG) ? '0 : rm_val;
  end

  lsr_shifter #(.DATA_W(DATA_W)) u_shift (
    .src(op_b), .wide(dec.wide), .kind(dec.kind),
    .amt(dec.amt[AMT_W-1:0]), .dst(op_b_sh)
  );

  lsr_logic #(.DATA_W(DATA_W)) u_logic (
    .a(op_a), .b(op_b_sh), .wide(dec.wide), .fn(dec.fn),
    .y(logic_y), .neg(flag_n), .zero(flag_z)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
      rd_q      <= '0;
      we_q      <= 1'b0;
      fwe_q     <= 1'b0;
      undef_q   <= 1'b0;
      nzcv_q    <= '0;
    end else begin
      if (accept)         out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      if (accept) begin
        res_q   <= dec.bad ? '0 : logic_y;
        rd_q    <= dec.dst;
        we_q    <= !dec.bad;
        fwe_q   <= !dec.bad && dec.sets_flags;
        undef_q <= dec.bad;
        nzcv_q  <= (!dec.bad && dec.sets_flags) ? {flag_n, flag_z, 2'b00} : 4'b0000;
      end
    end
  end

  assign res      = res_q;
  assign rd_idx   = rd_q;
  assign rd_we    = out_valid && we_q;
  assign flags_we = out_valid && fwe_q;
  assign undef    = out_valid && undef_q;
  assign nzcv     = nzcv_q;

  // R11: an accepted request is presented on the next edge
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  // R11: stalled output is held unchanged
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res) && $stable(nzcv) && $stable(rd_idx));
  // R4: 32-bit results leave the upper half clear
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !dec.wide |-> logic_y[DATA_W-1:HALF_W] == '0);
  // R5: undefined encodings write nothing
  p_undef_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !rd_we && !flags_we);
  // R7: flag updates clear carry and overflow
  p_cv_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> nzcv[1:0] == 2'b00 && rd_we);
endmodule

// File: tb/sim_lsr_alu.sv
`timescale 1ns/1ps
module sim_lsr_alu;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, out_ready = 1;
  logic [31:0] insn = '0;
  logic [63:0] rn_val = '0, rm_val = '0;
  logic        in_ready, out_valid, rd_we, flags_we, undef;
  logic [63:0] res;
  logic [4:0]  rd_idx;
  logic [3:0]  nzcv;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lsr_alu u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .rn_val(rn_val), .rm_val(rm_val), .out_valid(out_valid),
    .out_ready(out_ready), .res(res), .rd_idx(rd_idx), .rd_we(rd_we),
    .nzcv(nzcv), .flags_we(flags_we), .undef(undef));

  function automatic logic [31:0] mk(logic sf, logic [1:0] opc, logic [1:0] sh, logic n,
                                     logic [4:0] rm, logic [5:0] imm, logic [4:0] rn, logic [4:0] rd);
    return {sf, opc, 5'b01010, sh, n, rm, imm, rn, rd};
  endfunction

  function automatic logic [63:0] ref_shift(logic [63:0] v, logic sf, logic [1:0] k, int a);
    logic [31:0] x;
    logic [63:0] r;
    if (sf) begin
      case (k)
        2'd0: r = v << a;
        2'd1: r = v >> a;
        2'd2: r = $signed(v) >>> a;
        default: r = (a == 0) ? v : ((v >> a) | (v << (64 - a)));
      endcase
    end else begin
      x = v[31:0];
      case (k)
        2'd0: x = x << a;
        2'd1: x = x >> a;
        2'd2: x = $signed(x) >>> a;
        default: x = (a == 0) ? x : ((x >> a) | (x << (32 - a)));
      endcase
      r = {32'h0, x};
    end
    return r;
  endfunction

  task automatic fail_or_pass(string tag, logic ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [31:0] i, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    insn = i; rn_val = a; rm_val = b; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  // send one request and compare every output field against the reference
  task automatic run_case(string tag, logic [31:0] i, logic [63:0] a, logic [63:0] b);
    logic sf, bad, fl;
    logic [63:0] av, bv, e;
    logic [2:0] fn;
    logic n;
    sf = i[31];
    bad = (i[28:24] != 5'b01010) || (!sf && i[15]);
    fl = !bad && (i[30:29] == 2'd3);
    av = (i[9:5] == 5'd31) ? 64'h0 : a;
    bv = (i[20:16] == 5'd31) ? 64'h0 : b;
    bv = ref_shift(bv, sf, i[23:22], int'(i[15:10]));
    if (i[21]) bv = ~bv;
    case (i[30:29])
      2'd1: e = av | bv;
      2'd2: e = av ^ bv;
      default: e = av & bv;
    endcase
    if (!sf) e = {32'h0, e[31:0]};
    n = sf ? e[63] : e[31];
    send(i, a, b);
    fail_or_pass({tag, " valid"}, out_valid === 1'b1, 64'(out_valid), 64'd1);
    fail_or_pass({tag, " undef"}, undef === bad, 64'(undef), 64'(bad));
    fail_or_pass({tag, " rd_we"}, rd_we === !bad, 64'(rd_we), 64'(!bad));
    fail_or_pass({tag, " flags_we"}, flags_we === fl, 64'(flags_we), 64'(fl));
    if (!bad) begin
      fail_or_pass({tag, " res"}, res === e, res, e);
      fail_or_pass({tag, " R12 rd_idx"}, rd_idx === i[4:0], 64'(rd_idx), 64'(i[4:0]));
    end
    if (fl)
      fail_or_pass({tag, " nzcv"}, nzcv === {n, e == 64'h0, 2'b00}, 64'(nzcv), 64'({n, e == 64'h0, 2'b00}));
  endtask

  task automatic t_reset;
    fail_or_pass("R11 reset out_valid", out_valid === 1'b0, 64'(out_valid), 64'd0);
    fail_or_pass("R11 reset in_ready", in_ready === 1'b1, 64'(in_ready), 64'd1);
  endtask

  task automatic t_funcs;
    for (int f = 0; f < 8; f++)
      run_case($sformatf("R1 fn%0d", f),
               mk(1'b1, f[1:0], 2'd0, f[2], 5'd2, 6'd4, 5'd1, 5'(f + 3)),
               64'hF0F0_1234_5678_9ABC, 64'h0FF0_0FF0_A5A5_3C3C);
  endtask

  task automatic t_shifts;
    for (int k = 0; k < 4; k++) begin
      run_case("R2 shift64", mk(1'b1, 2'd2, k[1:0], 1'b0, 5'd4, 6'd12, 5'd5, 5'd6),
               64'h1111_2222_3333_4444, 64'h8000_00AB_CDEF_0123);
      run_case("R10 zero amount", mk(1'b1, 2'd2, k[1:0], 1'b0, 5'd4, 6'd0, 5'd31, 5'd6),
               64'h0, 64'h8123_4567_89AB_CDEF);
      run_case("R3 shift32", mk(1'b0, 2'd1, k[1:0], 1'b0, 5'd4, 6'd7, 5'd5, 5'd6),
               64'hFFFF_FFFF_0000_0010, 64'hDEAD_BEEF_8000_0F01);
    end
    run_case("R2 max amount", mk(1'b1, 2'd1, 2'd3, 1'b0, 5'd4, 6'd63, 5'd31, 5'd6),
             64'h0, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_32bit;
    // ASR by 4 of 0x80000000 ANDed with all ones gives 0xF8000000
    send(mk(1'b0, 2'd0, 2'd2, 1'b0, 5'd3, 6'd4, 5'd2, 5'd1), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_8000_0000);
    fail_or_pass("R3 asr32", res === 64'h0000_0000_F800_0000, res, 64'h0000_0000_F800_0000);
    // ROR by 1 of 1 within 32 bits gives 0x80000000
    send(mk(1'b0, 2'd1, 2'd3, 1'b0, 5'd3, 6'd1, 5'd31, 5'd1), 64'h0, 64'hFFFF_FFFF_0000_0001);
    fail_or_pass("R3 ror32", res === 64'h0000_0000_8000_0000, res, 64'h0000_0000_8000_0000);
    // EON in 32-bit mode: inverted operand must not leak into upper half
    send(mk(1'b0, 2'd2, 2'd0, 1'b1, 5'd3, 6'd0, 5'd2, 5'd1), 64'hFFFF_FFFF_0000_0000, 64'h0);
    fail_or_pass("R4 eon32 upper", res === 64'h0000_0000_FFFF_FFFF, res, 64'h0000_0000_FFFF_FFFF);
    run_case("R4 bic32", mk(1'b0, 2'd0, 2'd1, 1'b1, 5'd3, 6'd3, 5'd2, 5'd1),
             64'hAAAA_AAAA_5555_5555, 64'hFFFF_0000_F0F0_F0F0);
  endtask

  task automatic t_undef;
    send(mk(1'b0, 2'd3, 2'd0, 1'b0, 5'd3, 6'd32, 5'd2, 5'd1), 64'h1, 64'h1);
    fail_or_pass("R5 undef", undef === 1'b1, 64'(undef), 64'd1);
    fail_or_pass("R5 no write", rd_we === 1'b0 && flags_we === 1'b0, 64'({rd_we, flags_we}), 64'd0);
    run_case("R5 sf1 imm32 ok", mk(1'b1, 2'd3, 2'd0, 1'b0, 5'd3, 6'd32, 5'd2, 5'd1), 64'hFFFF_FFFF_0000_0000, 64'h1);
    send({1'b1, 2'd1, 5'b01011, 19'h0, 5'd7}, 64'h5, 64'h5);
    fail_or_pass("R6 bad tag undef", undef === 1'b1 && rd_we === 1'b0 && flags_we === 1'b0,
                 64'({undef, rd_we, flags_we}), 64'b100);
  endtask

  task automatic t_flags;
    send(mk(1'b1, 2'd3, 2'd0, 1'b0, 5'd3, 6'd0, 5'd2, 5'd1), 64'hFF00, 64'h00FF);
    fail_or_pass("R7 ands zero", flags_we === 1'b1 && nzcv === 4'b0100, 64'({flags_we, nzcv}), 64'b10100);
    send(mk(1'b1, 2'd3, 2'd0, 1'b1, 5'd3, 6'd0, 5'd2, 5'd1), 64'h8000_0000_0000_0000, 64'h0);
    fail_or_pass("R7 bics neg64", nzcv === 4'b1000, 64'(nzcv), 64'b1000);
    send(mk(1'b0, 2'd3, 2'd0, 1'b0, 5'd3, 6'd0, 5'd2, 5'd1), 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_8000_0000);
    fail_or_pass("R7 ands neg32", nzcv === 4'b1000, 64'(nzcv), 64'b1000);
    send(mk(1'b0, 2'd3, 2'd0, 1'b0, 5'd3, 6'd0, 5'd2, 5'd1), 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    fail_or_pass("R7 ands32 upper ignored", nzcv === 4'b0100, 64'(nzcv), 64'b0100);
    send(mk(1'b1, 2'd1, 2'd0, 1'b0, 5'd3, 6'd0, 5'd2, 5'd1), 64'h0, 64'h0);
    fail_or_pass("R7 orr no flags", flags_we === 1'b0, 64'(flags_we), 64'd0);
  endtask

  task automatic t_zero_reg;
    send(mk(1'b1, 2'd1, 2'd0, 1'b0, 5'd3, 6'd0, 5'd31, 5'd1), 64'hDEAD_DEAD_DEAD_DEAD, 64'h0000_0000_0000_0042);
    fail_or_pass("R8 rn31 zero", res === 64'h42, res, 64'h42);
    send(mk(1'b1, 2'd1, 2'd0, 1'b0, 5'd31, 6'd0, 5'd2, 5'd1), 64'h77, 64'hDEAD_DEAD_DEAD_DEAD);
    fail_or_pass("R8 rm31 zero", res === 64'h77, res, 64'h77);
  endtask

  task automatic t_mov;
    send(mk(1'b1, 2'd1, 2'd0, 1'b0, 5'd9, 6'd0, 5'd31, 5'd4), 64'h1, 64'hCAFE_F00D_1234_5678);
    fail_or_pass("R9 mov64", res === 64'hCAFE_F00D_1234_5678, res, 64'hCAFE_F00D_1234_5678);
    send(mk(1'b1, 2'd1, 2'd0, 1'b1, 5'd9, 6'd0, 5'd31, 5'd4), 64'h1, 64'hCAFE_F00D_1234_5678);
    fail_or_pass("R9 mvn64", res === ~64'hCAFE_F00D_1234_5678, res, ~64'hCAFE_F00D_1234_5678);
    send(mk(1'b0, 2'd1, 2'd0, 1'b1, 5'd9, 6'd0, 5'd31, 5'd4), 64'h1, 64'hCAFE_F00D_1234_5678);
    fail_or_pass("R9 mvn32", res === 64'h0000_0000_EDCB_A987, res, 64'h0000_0000_EDCB_A987);
  endtask

  task automatic t_backpressure;
    logic [63:0] held;
    @(negedge clk);
    out_ready = 0;
    insn = mk(1'b1, 2'd2, 2'd0, 1'b0, 5'd3, 6'd8, 5'd2, 5'd1);
    rn_val = 64'h0123; rm_val = 64'h0001; in_valid = 1;
    @(negedge clk);
    fail_or_pass("R11 accepted", out_valid === 1'b1, 64'(out_valid), 64'd1);
    held = res;
    // offer a second request that must not be taken
    insn = mk(1'b1, 2'd1, 2'd0, 1'b0, 5'd3, 6'd0, 5'd2, 5'd9);
    rn_val = 64'hFFFF; rm_val = 64'h0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      fail_or_pass("R11 hold", out_valid === 1'b1 && in_ready === 1'b0 && res === held && rd_idx === 5'd1,
                   res, held);
    end
    fail_or_pass("R11 held value", held === 64'h0023, held, 64'h0023);
    in_valid = 0;
    out_ready = 1;
    @(negedge clk);
    fail_or_pass("R11 drained", out_valid === 1'b0 && in_ready === 1'b1, 64'({out_valid, in_ready}), 64'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_funcs();
    t_shifts();
    t_32bit();
    t_undef();
    t_flags();
    t_zero_reg();
    t_mov();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule